// File: doc/BRIEF.md
# I2C Addressed Slave Transmitter

This block is the target side of a status-coded I2C controller. It watches SCL and SDA through a synchronizer. It collects the first byte after every START and compares it with a programmable 7-bit own address. When general-call response is enabled, it also accepts the all-zero address. It answers with an ACK or leaves SDA released, depending on an acknowledge-enable bit held by software. When it is addressed for reading, it sends bytes that software writes into a data register, most significant bit first.

Every bus event that needs software attention raises an interrupt flag and posts an 8-bit status code. While the flag is up, the block holds SCL low. Software reads the code, supplies the next byte or changes the acknowledge-enable bit, and then pulses a clear strobe. If arbitration is lost as a master and the block is then addressed, it enters target mode with a status code of its own. If acknowledge-enable is dropped while a byte is being loaded, that byte becomes the last one. The block then stops driving the bus, so a master that keeps reading sees only ones. Receiving data bytes after a write-direction address is left to a separate receive path. This block only acknowledges the address and reports it.

Top module: `i2cs_slave_tx`

## Requirements
- R1: After reset, and whenever the interrupt flag is clear, `status` reads F8h. Neither `scl_hold` nor `sda_low` is asserted while the block is idle.
- R2: When `enable` and `ack_en` are 1, an address byte equal to `{own_addr, 1}` (address in bits 7:1, read flag in bit 0) is ACKed in the ninth clock. On the falling SCL edge after that ACK, the flag rises with status A8h.
- R3: An address byte that matches neither the own address nor an enabled general call is not acknowledged (SDA stays released), and the flag stays clear.
- R4: While `ack_en` is 0, own-address and general-call bytes are not acknowledged and raise no flag. START and STOP are still tracked, so the next address after `ack_en` returns is recognized normally.
- R5: The byte 00h is ACKed only when `gc_en` is 1, and posts status 70h. The byte 01h is never acknowledged as a general call.
- R6: An own address with write flag (bit 0 = 0) is ACKed and posts 60h. After the clear, the block leaves the bus alone until the next START.
- R7: `scl_hold` is asserted exactly while the interrupt flag is set. A `si_clr` pulse releases SCL and clears the flag in the next cycle.
- R8: On the clear that follows A8h or B8h, the data register is loaded and shifted out MSB first, one bit per SCL low phase. `sda_low` changes only while SCL is low.
- R9: After a data byte, a master ACK posts B8h and the block sends the next byte. A master NACK posts C0h and leaves the block not addressed.
- R10: If `ack_en` is 0 when a byte is loaded, that byte is the last one. A master ACK then posts C8h, and the block releases SDA so that further reads return FFh without any flag.
- R11: A pulse on `arb_lost` between a START and the address decision changes the codes: an own read posts B0h, an own write posts 68h, and a general call posts 78h.
- R12: While `enable` is 0, the block drives neither bus line, raises no flag, and acknowledges no address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; when low, state is held idle |
| ack_en | input | 1 | Acknowledge enable for addresses; when low at byte load, marks the last byte |
| gc_en | input | 1 | Respond to the general-call address 00h |
| own_addr | input | ADDR_W | Own 7-bit target address |
| arb_lost | input | 1 | Pulse from the master side: arbitration lost during the current address phase |
| tx_wr | input | 1 | Write strobe for the transmit data register |
| tx_wdata | input | ADDR_W+1 | Transmit byte |
| si_clr | input | 1 | Clear strobe for the interrupt flag; resumes the bus |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| irq_flag | output | 1 | Interrupt flag, set on every reported event |
| status | output | 8 | Status code of the pending event, F8h when none |
| scl_hold | output | 1 | Pull SCL low (clock stretching) |
| sda_low | output | 1 | Pull SDA low (ACK or a 0 data bit) |

## Verification
Each kind of corrupted internal state shows up at the ports. A wrong match decision or a wrong arbitration latch appears at the very next flag as a different status code, or as an ACK bit of the wrong polarity in the ninth clock. A corrupted shift register or bit counter puts a wrong bit into the byte the master assembles, within the same byte. A wrong last-byte or NACK record appears one byte later, as a B8h/C0h/C8h mix-up or as a non-FFh read. A state that never leaves the hold phase freezes SCL low, so the master stalls and the run ends on its deadline.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_HOLD,
        ST_TX,
        ST_MACK
    } st_e;

    typedef enum logic {
        NXT_IDLE,
        NXT_TX
    } nxt_e;

    typedef enum logic [1:0] {
        HIT_NONE,
        HIT_OWN_R,
        HIT_OWN_W,
        HIT_GCALL
    } hit_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    localparam logic [7:0] SC_IDLE      = 8'hF8;
    localparam logic [7:0] SC_OWN_W     = 8'h60;
    localparam logic [7:0] SC_OWN_W_ARB = 8'h68;
    localparam logic [7:0] SC_GC        = 8'h70;
    localparam logic [7:0] SC_GC_ARB    = 8'h78;
    localparam logic [7:0] SC_OWN_R     = 8'hA8;
    localparam logic [7:0] SC_OWN_R_ARB = 8'hB0;
    localparam logic [7:0] SC_TX_ACK    = 8'hB8;
    localparam logic [7:0] SC_TX_NACK   = 8'hC0;
    localparam logic [7:0] SC_TX_LAST   = 8'hC8;

    function automatic logic [7:0] addr_code(input hit_e h, input logic arb);
        logic [7:0] c;
        case (h)
            HIT_OWN_R: c = arb ? SC_OWN_R_ARB : SC_OWN_R;
            HIT_OWN_W: c = arb ? SC_OWN_W_ARB : SC_OWN_W;
            HIT_GCALL: c = arb ? SC_GC_ARB    : SC_GC;
            default:   c = SC_IDLE;
        endcase
        return c;
    endfunction

    function automatic logic [7:0] tx_code(input logic nack, input logic last);
        logic [7:0] c;
        if (nack)      c = SC_TX_NACK;
        else if (last) c = SC_TX_LAST;
        else           c = SC_TX_ACK;
        return c;
    endfunction

endpackage

// File: rtl/i2cs_bus_monitor.sv
module i2cs_bus_monitor
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] scl_sr;
    logic [TOP:0] sda_sr;
    logic         scl_p;
    logic         sda_p;
    logic         scl_q;
    logic         sda_q;

    assign scl_q = scl_sr[TOP];
    assign sda_q = sda_sr[TOP];

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sr <= '1;
                    sda_sr <= '1;
                end else begin
                    scl_sr <= {scl_sr[TOP-1:0], scl_in};
                    sda_sr <= {sda_sr[TOP-1:0], sda_in};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sr <= '1;
                    sda_sr <= '1;
                end else begin
                    scl_sr <= scl_in;
                    sda_sr <= sda_in;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_q;
            sda_p <= sda_q;
        end
    end

    always_comb begin
        ev.start = scl_q & scl_p & sda_p & ~sda_q;
        ev.stop  = scl_q & scl_p & ~sda_p & sda_q;
        ev.rise  = scl_q & ~scl_p;
        ev.fall  = ~scl_q & scl_p;
        ev.sda   = sda_q;
    end

endmodule

// File: rtl/i2cs_addr_match.sv
module i2cs_addr_match
    import i2cs_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W:0]   addr_byte,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gc_en,
    output hit_e              hit
);
    logic is_zero;
    logic is_own;

    assign is_zero = (addr_byte == '0);
    assign is_own  = (addr_byte[ADDR_W:1] == own_addr);

    always_comb begin
        if (is_zero)
            hit = gc_en ? HIT_GCALL : HIT_NONE;
        else if (is_own)
            hit = addr_byte[0] ? HIT_OWN_R : HIT_OWN_W;
        else
            hit = HIT_NONE;
    end

endmodule

// File: rtl/i2cs_tx_shifter.sv
module i2cs_tx_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] din,
    input  logic              shift,
    output logic              bit_out
);
    logic [BYTE_W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst)
            sr <= '1;
        else if (load)
            sr <= din;
        else if (shift)
            sr <= {sr[BYTE_W-2:0], 1'b1};
    end

    assign bit_out = sr[BYTE_W-1];

endmodule

// File: rtl/i2cs_slave_tx.sv
module i2cs_slave_tx
    import i2cs_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              ack_en,
    input  logic              gc_en,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              arb_lost,
    input  logic              tx_wr,
    input  logic [ADDR_W:0]   tx_wdata,
    input  logic              si_clr,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              irq_flag,
    output logic [7:0]        status,
    output logic              scl_hold,
    output logic              sda_low
);
    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    bus_ev_t           ev;
    hit_e              hit;
    hit_e              hit_q;
    st_e               state;
    nxt_e              nxt;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] addr_sr;
    logic [BYTE_W-1:0] dreg;
    logic              arb_q;
    logic              last_q;
    logic              nack_q;
    logic [7:0]        status_q;
    logic              flag_q;
    logic              sh_load;
    logic              sh_shift;
    logic              sh_bit;
    logic              soft_rst;

    assign soft_rst = rst | ~enable;

    i2cs_bus_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    i2cs_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .addr_byte (addr_sr),
        .own_addr  (own_addr),
        .gc_en     (gc_en),
        .hit       (hit)
    );

    assign sh_load  = (state == ST_HOLD) && si_clr && (nxt == NXT_TX);
    assign sh_shift = (state == ST_TX) && ev.fall && (cnt != CNT_LAST);

    i2cs_tx_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk     (clk),
        .rst     (soft_rst),
        .load    (sh_load),
        .din     (dreg),
        .shift   (sh_shift),
        .bit_out (sh_bit)
    );

    // software data register
    always_ff @(posedge clk) begin
        if (rst)
            dreg <= '1;
        else if (tx_wr)
            dreg <= tx_wdata;
    end

    // protocol sequencer
    always_ff @(posedge clk) begin
        if (soft_rst) begin
            state    <= ST_IDLE;
            nxt      <= NXT_IDLE;
            cnt      <= '0;
            addr_sr  <= '0;
            hit_q    <= HIT_NONE;
            arb_q    <= 1'b0;
            last_q   <= 1'b0;
            nack_q   <= 1'b0;
            flag_q   <= 1'b0;
            status_q <= SC_IDLE;
        end else begin
            if (arb_lost)
                arb_q <= 1'b1;
            if (ev.start && state != ST_HOLD) begin
                state <= ST_ADDR;
                cnt   <= '0;
                arb_q <= arb_lost;
            end else if (ev.stop && state != ST_HOLD) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (ev.rise) begin
                            addr_sr <= {addr_sr[BYTE_W-2:0], ev.sda};
                            cnt     <= cnt + 1'b1;
                        end else if (ev.fall && cnt == CNT_FULL) begin
                            if (hit != HIT_NONE && ack_en) begin
                                state <= ST_AACK;
                                hit_q <= hit;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (ev.fall) begin
                            state    <= ST_HOLD;
                            flag_q   <= 1'b1;
                            status_q <= addr_code(hit_q, arb_q);
                            nxt      <= (hit_q == HIT_OWN_R) ? NXT_TX : NXT_IDLE;
                        end
                    end
                    ST_HOLD: begin
                        if (si_clr) begin
                            flag_q   <= 1'b0;
                            status_q <= SC_IDLE;
                            if (nxt == NXT_TX) begin
                                state  <= ST_TX;
                                cnt    <= '0;
                                last_q <= ~ack_en;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev.fall) begin
                            if (cnt == CNT_LAST)
                                state <= ST_MACK;
                            else
                                cnt <= cnt + 1'b1;
                        end
                    end
                    ST_MACK: begin
                        if (ev.rise) begin
                            nack_q <= ev.sda;
                        end else if (ev.fall) begin
                            state    <= ST_HOLD;
                            flag_q   <= 1'b1;
                            status_q <= tx_code(nack_q, last_q);
                            nxt      <= (!nack_q && !last_q) ? NXT_TX : NXT_IDLE;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign irq_flag = flag_q;
    assign status   = status_q;
    assign scl_hold = (state == ST_HOLD);
    assign sda_low  = (state == ST_AACK) || ((state == ST_TX) && !sh_bit);

endmodule

// File: rtl/i2cs_slave_tx_checker.sv
module i2cs_slave_tx_checker (
    input logic       clk,
    input logic       rst,
    input logic       enable,
    input logic       scl_in,
    input logic       si_clr,
    input logic       irq_flag,
    input logic [7:0] status,
    input logic       scl_hold,
    input logic       sda_low
);

    AST_IDLE_CODE: assert property (@(posedge clk) disable iff (rst)
        !irq_flag |-> status == 8'hF8);                              // R1

    AST_FLAG_HAS_CODE: assert property (@(posedge clk) disable iff (rst)
        irq_flag |-> status != 8'hF8);                               // R2

    AST_STRETCH_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
        scl_hold == irq_flag);                                       // R7

    AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && si_clr) |=> (!scl_hold && !irq_flag));          // R7

    AST_SDA_MOVES_LOW_SCL: assert property (@(posedge clk) disable iff (rst || !enable)
        !$stable(sda_low) |-> !scl_in);                              // R8

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!sda_low && !scl_hold && !irq_flag));           // R12

endmodule

bind i2cs_slave_tx i2cs_slave_tx_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .scl_in   (scl_in),
    .si_clr   (si_clr),
    .irq_flag (irq_flag),
    .status   (status),
    .scl_hold (scl_hold),
    .sda_low  (sda_low)
);

// File: tb/i2cs_slave_tx_bench.sv
`timescale 1ns/1ps
module i2cs_slave_tx_bench;
    localparam int H = 8;
    localparam logic [6:0] OWN = 7'h5A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic       enable = 1'b1;
    logic       gc_en = 1'b0;
    logic       arb_lost = 1'b0;
    logic       sw_aa = 1'b1;
    logic       aa_off = 1'b0;
    logic       ack_en;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_wdata = 8'h00;
    logic       si_clr = 1'b0;
    logic       m_scl_low = 1'b0;
    logic       m_sda_low = 1'b0;
    logic       scl_line, sda_line;
    logic       irq_flag, scl_hold, sda_low;
    logic [7:0] status;

    assign ack_en   = sw_aa && !aa_off;
    assign scl_line = !(m_scl_low || scl_hold);
    assign sda_line = !(m_sda_low || sda_low);

    i2cs_slave_tx u_i2cs_slave_tx (
        .clk(clk), .rst(rst), .enable(enable), .ack_en(ack_en), .gc_en(gc_en),
        .own_addr(OWN), .arb_lost(arb_lost), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
        .si_clr(si_clr), .scl_in(scl_line), .sda_in(sda_line),
        .irq_flag(irq_flag), .status(status), .scl_hold(scl_hold), .sda_low(sda_low)
    );

    typedef struct {
        logic [7:0] code;
        logic [7:0] data;
        logic       aa;
        string      tag;
    } exp_t;

    exp_t expq[$];
    int n_vec = 0;
    int n_bad = 0;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] code, input logic [7:0] data,
                        input logic aa, input string tag);
        exp_t it;
        it.code = code; it.data = data; it.aa = aa; it.tag = tag;
        expq.push_back(it);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        tick(1);
        while (!scl_line) tick(1);
    endtask

    task automatic bus_bit(input logic b, output logic r);
        m_sda_low = !b;
        tick(H);
        m_scl_low = 1'b0;
        wait_scl_high();
        tick(H / 2);
        r = sda_line;
        tick(H / 2);
        m_scl_low = 1'b1;
        tick(2);
    endtask

    task automatic m_start();
        m_sda_low = 1'b0;
        tick(H);
        m_scl_low = 1'b0;
        wait_scl_high();
        tick(H);
        m_sda_low = 1'b1;
        tick(H);
        m_scl_low = 1'b1;
        tick(2);
    endtask

    task automatic m_stop();
        m_sda_low = 1'b1;
        tick(H);
        m_scl_low = 1'b0;
        wait_scl_high();
        tick(H);
        m_sda_low = 1'b0;
        tick(2 * H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic nack);
        logic r;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], r);
        bus_bit(1'b1, nack);
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic give_ack);
        logic r;
        d = 8'h00;
        for (int i = 0; i < 8; i++) begin
            bus_bit(1'b1, r);
            d = {d[6:0], r};
        end
        bus_bit(!give_ack, r);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // scoreboard monitor and software responder
    initial begin
        forever begin
            @(negedge clk);
            if (irq_flag) begin
                exp_t it;
                tick(4);
                chk("R7 SCL held while flag set", {7'b0, scl_line}, 8'h00);
                if (expq.size() == 0) begin
                    n_vec++;
                    n_bad++;
                    $display("FAIL R3 unexpected flag actual=%h expected=none", status);
                end else begin
                    it = expq.pop_front();
                    chk(it.tag, status, it.code);
                    tx_wdata = it.data;
                    tx_wr = 1'b1;
                    sw_aa = it.aa;
                    tick(1);
                    tx_wr = 1'b0;
                end
                si_clr = 1'b1;
                tick(1);
                si_clr = 1'b0;
                chk("R7 SCL released after clear", {7'b0, scl_hold}, 8'h00);
                chk("R1 code back to idle", status, 8'hF8);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic nk;
        logic [7:0] d;
        tick(5);
        rst = 1'b0;
        tick(4);
        chk("R1 reset flag", {7'b0, irq_flag}, 8'h00);
        chk("R1 reset status", status, 8'hF8);
        chk("R1 reset scl", {7'b0, scl_hold}, 8'h00);
        chk("R1 reset sda", {7'b0, sda_low}, 8'h00);

        // R2 R8 R9: two-byte read, ACK then NACK
        push(8'hA8, 8'hC3, 1'b1, "R2 own read status");
        push(8'hB8, 8'h3C, 1'b1, "R9 master ACK status");
        push(8'hC0, 8'h00, 1'b1, "R9 master NACK status");
        m_start();
        send_byte({OWN, 1'b1}, nk);
        chk("R2 own read acknowledged", {7'b0, nk}, 8'h00);
        recv_byte(d, 1'b1);
        chk("R8 first byte MSB first", d, 8'hC3);
        recv_byte(d, 1'b0);
        chk("R8 second byte", d, 8'h3C);
        m_stop();

        // R3 mismatch
        m_start();
        send_byte(8'hCD, nk);
        chk("R3 foreign address not acked", {7'b0, nk}, 8'h01);
        recv_byte(d, 1'b0);
        chk("R3 bus left released", d, 8'hFF);
        m_stop();
        chk("R3 no flag", {7'b0, irq_flag}, 8'h00);

        // R4 acknowledge disabled
        aa_off = 1'b1;
        m_start();
        send_byte({OWN, 1'b1}, nk);
        chk("R4 own address ignored with ack_en low", {7'b0, nk}, 8'h01);
        m_stop();
        aa_off = 1'b0;
        push(8'hA8, 8'h96, 1'b1, "R4 recognition resumes");
        push(8'hC0, 8'h00, 1'b1, "R9 NACK after resume");
        m_start();
        send_byte({OWN, 1'b1}, nk);
        chk("R4 own address acked again", {7'b0, nk}, 8'h00);
        recv_byte(d, 1'b0);
        chk("R8 byte after resume", d, 8'h96);
        m_stop();

        // R5 general call
        m_start();
        send_byte(8'h00, nk);
        chk("R5 general call ignored when disabled", {7'b0, nk}, 8'h01);
        m_stop();
        gc_en = 1'b1;
        push(8'h70, 8'h00, 1'b1, "R5 general call status");
        m_start();
        send_byte(8'h00, nk);
        chk("R5 general call acked", {7'b0, nk}, 8'h00);
        m_stop();
        m_start();
        send_byte(8'h01, nk);
        chk("R5 general call read not acked", {7'b0, nk}, 8'h01);
        m_stop();

        // R6 own write
        push(8'h60, 8'h00, 1'b1, "R6 own write status");
        m_start();
        send_byte({OWN, 1'b0}, nk);
        chk("R6 own write acked", {7'b0, nk}, 8'h00);
        m_stop();

        // R10 last byte then all ones
        push(8'hA8, 8'h81, 1'b0, "R10 read start status");
        push(8'hC8, 8'h00, 1'b1, "R10 last byte status");
        m_start();
        send_byte({OWN, 1'b1}, nk);
        recv_byte(d, 1'b1);
        chk("R10 final byte", d, 8'h81);
        recv_byte(d, 1'b1);
        chk("R10 reads all ones after exit", d, 8'hFF);
        m_stop();

        // R11 arbitration-loss entry
        push(8'hB0, 8'h55, 1'b1, "R11 read after lost arbitration");
        push(8'hC0, 8'h00, 1'b1, "R9 NACK after arbitration entry");
        m_start();
        arb_lost = 1'b1;
        tick(1);
        arb_lost = 1'b0;
        send_byte({OWN, 1'b1}, nk);
        recv_byte(d, 1'b0);
        chk("R11 byte after arbitration entry", d, 8'h55);
        m_stop();
        push(8'h68, 8'h00, 1'b1, "R11 write after lost arbitration");
        m_start();
        arb_lost = 1'b1;
        tick(1);
        arb_lost = 1'b0;
        send_byte({OWN, 1'b0}, nk);
        m_stop();
        push(8'h78, 8'h00, 1'b1, "R11 general call after lost arbitration");
        m_start();
        arb_lost = 1'b1;
        tick(1);
        arb_lost = 1'b0;
        send_byte(8'h00, nk);
        m_stop();

        // R12 disabled
        enable = 1'b0;
        m_start();
        send_byte({OWN, 1'b1}, nk);
        chk("R12 no ack while disabled", {7'b0, nk}, 8'h01);
        m_stop();
        chk("R12 no flag while disabled", {7'b0, irq_flag}, 8'h00);
        enable = 1'b1;

        tick(50);
        chk("R9 all expected events seen", 8'(expq.size()), 8'h00);
        finish_run();
    end

endmodule